// File: doc/BRIEF.md
# Latency-Aware Issue Interlock

This block sits in the issue stage of an in-order, single-issue pipeline that has separate integer and floating-point register files. Each cycle it looks at one issue candidate: an operation class, a destination register, two general source operands and a separately flagged store-data operand. It tells the issue logic to hold the candidate for as long as any operand would read a value that its producer has not yet made available.

How long a consumer has to wait depends on two things: which class of operation produced the value, and how the consumer uses it. A value that only has to be written to memory by a store is forwarded sooner than a value that feeds arithmetic. A branch that tests an integer result needs one cycle more than an arithmetic consumer would. The unit keeps a short time-indexed history of the producers that issued in the last few cycles. It compares each valid operand against the youngest matching entry in that history. It also keeps a running count of stalled cycles, which can be read at its output.

Top module: `issue_interlock`

## Requirements
- R1: An FP ALU result read as a general source by a later instruction needs 3 intervening cycles. A directly following consumer stalls for exactly 3 cycles.
- R2: An FP ALU result used as store data needs 2 intervening cycles, so a directly following store stalls for 2 cycles.
- R3: An FP load result read as a general source needs 1 intervening cycle.
- R4: An FP load result used as store data needs no intervening cycle. A directly following store does not stall.
- R5: An integer load result needs 1 intervening cycle before any consumer reads it.
- R6: An integer ALU result can be read as a general source by the very next non-branch instruction with no stall.
- R7: When a branch (class 5) tests the result of the integer ALU operation directly before it, the branch stalls for 1 cycle.
- R8: The store's address base, given on source A, follows the general-source rules and not the store-data rules.
- R9: Stall is only ever high while candValid is high. A stalled candidate is not recorded, even if it is withdrawn afterwards. The history still ages by one cycle on every clock, stalled or not.
- R10: Operand tags are REG_IDX_W+1 bits wide. The top bit set means the FP file and clear means the integer file. A match needs both the file and the index to agree, and an operand whose valid bit is low is never checked. The class codes are 0 = integer ALU, 1 = integer load, 2 = FP ALU, 3 = FP load, 4 = FP store and 5 = branch. Classes 0 and 1 write the integer file, classes 2 and 3 write the FP file, and classes 4 and 5 write nothing.
- R11: When several recent producers write the same register, only the youngest of them decides whether there is a hazard.
- R12: A synchronous reset clears every in-flight record and sets the stall counter to zero.
- R13: The stall counter goes up by exactly one in each cycle where stall is high, and holds its value in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| candValid | input | 1 | An issue candidate is present |
| candClass | input | 3 | Operation class of the candidate |
| candDest | input | REG_IDX_W | Destination index; the class implies the register file |
| srcAValid | input | 1 | Source A is in use |
| srcATag | input | REG_IDX_W+1 | Source A tag (file bit and index); holds the base for a store |
| srcBValid | input | 1 | Source B is in use |
| srcBTag | input | REG_IDX_W+1 | Source B tag |
| stDataValid | input | 1 | Store-data operand is in use |
| stDataTag | input | REG_IDX_W+1 | Store-data tag |
| stall | output | 1 | Hold the candidate this cycle |
| stallCount | output | CNT_W | Running count of stalled cycles |

## Verification
Back-to-back producer and consumer pairs are run for every combination of producer class and consumer role. The number of stalls seen on each pair shows whether that pair's latency is right. Cases with the same index in the other file, and with invalid operands, show that a match needs both the file and the index to agree. A pair of writers to one register, where the older writer has the longer latency, shows that the youngest writer decides the hazard. A candidate that is withdrawn while stalled, and a reset taken with a producer in flight, show what is recorded and what is cleared. A long random stream then compares stall and the counter on every cycle against a behavioural model that keeps its history in queues.

// File: rtl/ilk_pkg.sv
package ilk_pkg;

  typedef enum logic [2:0] {
    OP_INT_ALU  = 3'd0,
    OP_INT_LOAD = 3'd1,
    OP_FP_ALU   = 3'd2,
    OP_FP_LOAD  = 3'd3,
    OP_FP_STORE = 3'd4,
    OP_BRANCH   = 3'd5
  } opClass_e;

  typedef enum logic [1:0] {
    ROLE_ARITH  = 2'd0,
    ROLE_STDATA = 2'd1,
    ROLE_BRANCH = 2'd2
  } opRole_e;

  // strobes from control to datapath
  typedef struct packed {
    logic push;        // record the candidate as issued
    logic countStall;  // bump the stall counter
  } ilkStrobe_t;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic writesReg(input logic [2:0] cls);
    return (cls == OP_INT_ALU) || (cls == OP_INT_LOAD) ||
           (cls == OP_FP_ALU)  || (cls == OP_FP_LOAD);
  endfunction

  function automatic logic writesFp(input logic [2:0] cls);
    return (cls == OP_FP_ALU) || (cls == OP_FP_LOAD);
  endfunction

endpackage

// File: rtl/ilk_operand_check.sv
module ilk_operand_check
  import ilk_pkg::*;
#(
  parameter int REG_IDX_W   = 5,
  parameter int HIST_DEPTH  = 3,
  parameter int LAT_FPA_FPA = 3,
  parameter int LAT_FPA_STD = 2,
  parameter int LAT_FLD_FPA = 1,
  parameter int LAT_FLD_STD = 0,
  parameter int LAT_ILD     = 1,
  parameter int LAT_IALU    = 0,
  parameter int LAT_IALU_BR = 1
) (
  input  logic                                  opValid,
  input  logic [REG_IDX_W:0]                    opTag,
  input  opRole_e                               opRole,
  input  logic [HIST_DEPTH-1:0]                 histValid,
  input  logic [HIST_DEPTH-1:0][2:0]            histCls,
  input  logic [HIST_DEPTH-1:0][REG_IDX_W-1:0]  histIdx,
  output logic                                  hazard
);

  function automatic int needCycles(input logic [2:0] cls, input opRole_e role);
    int n;
    case (cls)
      OP_INT_ALU:  n = (role == ROLE_BRANCH) ? LAT_IALU_BR : LAT_IALU;
      OP_INT_LOAD: n = LAT_ILD;
      OP_FP_ALU:   n = (role == ROLE_STDATA) ? LAT_FPA_STD : LAT_FPA_FPA;
      OP_FP_LOAD:  n = (role == ROLE_STDATA) ? LAT_FLD_STD : LAT_FLD_FPA;
      default:     n = 0;
    endcase
    return n;
  endfunction

  logic found;

  // slot 0 is the youngest; the first match wins
  always_comb begin
    hazard = 1'b0;
    found  = 1'b0;
    for (int k = 0; k < HIST_DEPTH; k++) begin
      if (!found && opValid && histValid[k] &&
          (writesFp(histCls[k]) == opTag[REG_IDX_W]) &&
          (histIdx[k] == opTag[REG_IDX_W-1:0])) begin
        found  = 1'b1;
        hazard = ((k + 1) <= needCycles(histCls[k], opRole));
      end
    end
  end

endmodule

// File: rtl/ilk_datapath.sv
module ilk_datapath
  import ilk_pkg::*;
#(
  parameter int REG_IDX_W   = 5,
  parameter int CNT_W       = 32,
  parameter int NUM_OPS     = 3,
  parameter int HIST_DEPTH  = 3,
  parameter int LAT_FPA_FPA = 3,
  parameter int LAT_FPA_STD = 2,
  parameter int LAT_FLD_FPA = 1,
  parameter int LAT_FLD_STD = 0,
  parameter int LAT_ILD     = 1,
  parameter int LAT_IALU    = 0,
  parameter int LAT_IALU_BR = 1
) (
  input  logic                               clk,
  input  logic                               rst,
  input  ilkStrobe_t                         strb,
  input  logic [2:0]                         candClass,
  input  logic [REG_IDX_W-1:0]               candDest,
  input  logic [NUM_OPS-1:0]                 opValid,
  input  logic [NUM_OPS-1:0][REG_IDX_W:0]    opTag,
  input  logic [NUM_OPS-1:0]                 opIsStData,
  output logic [NUM_OPS-1:0]                 hazardVec,
  output logic [CNT_W-1:0]                   stallCount
);

  logic [HIST_DEPTH-1:0]                histValid;
  logic [HIST_DEPTH-1:0][2:0]           histCls;
  logic [HIST_DEPTH-1:0][REG_IDX_W-1:0] histIdx;
  logic [CNT_W-1:0]                     cntQ;

  // time-indexed history: entry k issued k+1 cycles ago
  always_ff @(posedge clk) begin
    if (rst) begin
      histValid <= '0;
      histCls   <= '0;
      histIdx   <= '0;
      cntQ      <= '0;
    end else begin
      histValid[0] <= strb.push && writesReg(candClass);
      histCls[0]   <= candClass;
      histIdx[0]   <= candDest;
      for (int k = 1; k < HIST_DEPTH; k++) begin
        histValid[k] <= histValid[k-1];
        histCls[k]   <= histCls[k-1];
        histIdx[k]   <= histIdx[k-1];
      end
      cntQ <= cntQ + CNT_W'(strb.countStall);
    end
  end

  assign stallCount = cntQ;

  generate
    for (genvar g = 0; g < NUM_OPS; g++) begin : gOp
      opRole_e role;
      always_comb begin
        if (opIsStData[g])                role = ROLE_STDATA;
        else if (candClass == OP_BRANCH)  role = ROLE_BRANCH;
        else                              role = ROLE_ARITH;
      end

      ilk_operand_check #(
        .REG_IDX_W  (REG_IDX_W),
        .HIST_DEPTH (HIST_DEPTH),
        .LAT_FPA_FPA(LAT_FPA_FPA),
        .LAT_FPA_STD(LAT_FPA_STD),
        .LAT_FLD_FPA(LAT_FLD_FPA),
        .LAT_FLD_STD(LAT_FLD_STD),
        .LAT_ILD    (LAT_ILD),
        .LAT_IALU   (LAT_IALU),
        .LAT_IALU_BR(LAT_IALU_BR)
      ) u_chk (
        .opValid  (opValid[g]),
        .opTag    (opTag[g]),
        .opRole   (role),
        .histValid(histValid),
        .histCls  (histCls),
        .histIdx  (histIdx),
        .hazard   (hazardVec[g])
      );
    end
  endgenerate

endmodule

// File: rtl/ilk_control.sv
module ilk_control
  import ilk_pkg::*;
#(
  parameter int NUM_OPS = 3
) (
  input  logic               candValid,
  input  logic [NUM_OPS-1:0] hazardVec,
  output logic               stall,
  output ilkStrobe_t         strb
);

  always_comb begin
    stall           = candValid && (|hazardVec);
    strb.push       = candValid && !stall;
    strb.countStall = stall;
  end

endmodule

// File: rtl/issue_interlock.sv
module issue_interlock
  import ilk_pkg::*;
#(
  parameter int REG_IDX_W   = 5,
  parameter int CNT_W       = 32,
  parameter int LAT_FPA_FPA = 3,
  parameter int LAT_FPA_STD = 2,
  parameter int LAT_FLD_FPA = 1,
  parameter int LAT_FLD_STD = 0,
  parameter int LAT_ILD     = 1,
  parameter int LAT_IALU    = 0,
  parameter int LAT_IALU_BR = 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 candValid,
  input  logic [2:0]           candClass,
  input  logic [REG_IDX_W-1:0] candDest,
  input  logic                 srcAValid,
  input  logic [REG_IDX_W:0]   srcATag,
  input  logic                 srcBValid,
  input  logic [REG_IDX_W:0]   srcBTag,
  input  logic                 stDataValid,
  input  logic [REG_IDX_W:0]   stDataTag,
  output logic                 stall,
  output logic [CNT_W-1:0]     stallCount
);

  localparam int NUM_OPS = 3;
  localparam int MAX_LAT = maxOf(maxOf(maxOf(LAT_FPA_FPA, LAT_FPA_STD),
                                       maxOf(LAT_FLD_FPA, LAT_FLD_STD)),
                                 maxOf(maxOf(LAT_ILD, LAT_IALU), LAT_IALU_BR));
  localparam int HIST_DEPTH = maxOf(MAX_LAT, 1);

  logic [NUM_OPS-1:0]              opValid;
  logic [NUM_OPS-1:0][REG_IDX_W:0] opTag;
  logic [NUM_OPS-1:0]              opIsStData;
  logic [NUM_OPS-1:0]              hazardVec;
  ilkStrobe_t                      strb;

  assign opValid    = {stDataValid, srcBValid, srcAValid};
  assign opTag      = {stDataTag, srcBTag, srcATag};
  assign opIsStData = 3'b100;

  ilk_datapath #(
    .REG_IDX_W  (REG_IDX_W),
    .CNT_W      (CNT_W),
    .NUM_OPS    (NUM_OPS),
    .HIST_DEPTH (HIST_DEPTH),
    .LAT_FPA_FPA(LAT_FPA_FPA),
    .LAT_FPA_STD(LAT_FPA_STD),
    .LAT_FLD_FPA(LAT_FLD_FPA),
    .LAT_FLD_STD(LAT_FLD_STD),
    .LAT_ILD    (LAT_ILD),
    .LAT_IALU   (LAT_IALU),
    .LAT_IALU_BR(LAT_IALU_BR)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .candClass (candClass),
    .candDest  (candDest),
    .opValid   (opValid),
    .opTag     (opTag),
    .opIsStData(opIsStData),
    .hazardVec (hazardVec),
    .stallCount(stallCount)
  );

  ilk_control #(
    .NUM_OPS(NUM_OPS)
  ) u_ctl (
    .candValid(candValid),
    .hazardVec(hazardVec),
    .stall    (stall),
    .strb     (strb)
  );

endmodule

// File: rtl/issue_interlock_chk.sv
module issue_interlock_chk #(
  parameter int REG_IDX_W = 5,
  parameter int CNT_W     = 32
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 candValid,
  input logic [2:0]           candClass,
  input logic [REG_IDX_W-1:0] candDest,
  input logic                 srcAValid,
  input logic [REG_IDX_W:0]   srcATag,
  input logic                 srcBValid,
  input logic [REG_IDX_W:0]   srcBTag,
  input logic                 stDataValid,
  input logic [REG_IDX_W:0]   stDataTag,
  input logic                 stall,
  input logic [CNT_W-1:0]     stallCount
);

  AST_STALL_NEEDS_CAND: assert property (@(posedge clk) disable iff (rst)
    stall |-> candValid); // R9

  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !stall |=> stallCount == $past(stallCount)); // R13

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    stall |=> stallCount == $past(stallCount) + CNT_W'(1)); // R13

  AST_FPALU_CHAIN_STALLS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(candValid && !stall && candClass == 3'd2) &&
     candValid && candClass == 3'd2 && srcAValid &&
     srcATag == {1'b1, $past(candDest)}) |-> stall); // R1

  AST_FLD_TO_STORE_FREE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(candValid && !stall && candClass == 3'd3) &&
     candValid && stDataValid && !srcAValid && !srcBValid &&
     stDataTag == {1'b1, $past(candDest)}) |-> !stall); // R4

  AST_IALU_FORWARD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(candValid && !stall && candClass == 3'd0) &&
     candValid && candClass != 3'd5 && srcAValid && !srcBValid && !stDataValid &&
     srcATag == {1'b0, $past(candDest)}) |-> !stall); // R6

  AST_RESET_CLEAN: assert property (@(posedge clk)
    ($past(rst) && !rst) |-> (!stall && stallCount == '0)); // R12

endmodule

bind issue_interlock issue_interlock_chk #(
  .REG_IDX_W(REG_IDX_W),
  .CNT_W    (CNT_W)
) u_chk (.*);

// File: tb/issue_interlock_tb.sv
`timescale 1ns/1ps
module issue_interlock_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       candValid = 1'b0;
  logic [2:0] candClass = '0;
  logic [4:0] candDest = '0;
  logic       srcAValid = 1'b0;
  logic [5:0] srcATag = '0;
  logic       srcBValid = 1'b0;
  logic [5:0] srcBTag = '0;
  logic       stDataValid = 1'b0;
  logic [5:0] stDataTag = '0;
  logic       stall;
  logic [31:0] stallCount;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  int qCyc[$];
  int qCls[$];
  int qTag[$];
  int cycle = 0;
  int expCount = 0;

  always #5 clk = ~clk;

  issue_interlock u_dut (
    .clk(clk), .rst(rst), .candValid(candValid), .candClass(candClass),
    .candDest(candDest), .srcAValid(srcAValid), .srcATag(srcATag),
    .srcBValid(srcBValid), .srcBTag(srcBTag), .stDataValid(stDataValid),
    .stDataTag(stDataTag), .stall(stall), .stallCount(stallCount)
  );

  function automatic logic [5:0] fr(input int i); return {1'b1, 5'(i)}; endfunction
  function automatic logic [5:0] ir(input int i); return {1'b0, 5'(i)}; endfunction

  // roles: 0 arith, 1 store data, 2 branch
  function automatic int latOf(input int cls, input int role);
    case (cls)
      0: return (role == 2) ? 1 : 0;
      1: return 1;
      2: return (role == 1) ? 2 : 3;
      3: return (role == 1) ? 0 : 1;
      default: return 0;
    endcase
  endfunction

  function automatic bit hazardFor(input bit v, input logic [5:0] tag, input int role);
    if (!v) return 0;
    for (int i = qTag.size() - 1; i >= 0; i--)
      if (qTag[i] == int'(tag)) return (cycle - qCyc[i]) <= latOf(qCls[i], role);
    return 0;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input bit v, input int cls, input int dest,
                      input bit aV, input logic [5:0] aT,
                      input bit bV, input logic [5:0] bT,
                      input bit dV, input logic [5:0] dT,
                      input string req, output bit sawStall);
    bit expStall;
    int srcRole;
    @(negedge clk);
    candValid = v; candClass = 3'(cls); candDest = 5'(dest);
    srcAValid = aV; srcATag = aT; srcBValid = bV; srcBTag = bT;
    stDataValid = dV; stDataTag = dT;
    #1;
    srcRole = (cls == 5) ? 2 : 0;
    expStall = v && (hazardFor(aV, aT, srcRole) || hazardFor(bV, bT, srcRole) ||
                     hazardFor(dV, dT, 1));
    check(stall === expStall, req, "stall", longint'(stall), longint'(expStall));
    check(stallCount === 32'(expCount), req, "stallCount", longint'(stallCount), longint'(expCount));
    sawStall = stall;
    @(posedge clk);
    if (expStall) expCount++;
    else if (v && cls <= 3) begin
      qCyc.push_back(cycle);
      qCls.push_back(cls);
      qTag.push_back(int'({(cls == 2 || cls == 3) ? 1'b1 : 1'b0, 5'(dest)}));
    end
    cycle++;
    while (qCyc.size() > 0 && cycle - qCyc[0] > 8) begin
      void'(qCyc.pop_front()); void'(qCls.pop_front()); void'(qTag.pop_front());
    end
  endtask

  // repeat one candidate until accepted and check the stall count
  task automatic send(input int cls, input int dest,
                      input bit aV, input logic [5:0] aT,
                      input bit bV, input logic [5:0] bT,
                      input bit dV, input logic [5:0] dT,
                      input int expStalls, input string req);
    bit s;
    int n = 0;
    for (int i = 0; i < 10; i++) begin
      step(1, cls, dest, aV, aT, bV, bT, dV, dT, req, s);
      if (!s) break;
      n++;
    end
    check(n == expStalls, req, "stall cycles", n, expStalls);
  endtask

  task automatic idle(input int n);
    bit s;
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, '0, 0, '0, 0, '0, "idle", s);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; candValid = 1'b0;
    repeat (2) @(posedge clk);
    qCyc.delete(); qCls.delete(); qTag.delete();
    expCount = 0;
    @(negedge clk);
    rst = 1'b0;
    #1;
    check(stall === 1'b0, "R12", "stall after reset", longint'(stall), 0);
    check(stallCount === 32'd0, "R12", "count after reset", longint'(stallCount), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit s;
    int c0;
    doReset();

    // R1: FP ALU -> FP ALU source
    @(negedge clk); #1; c0 = int'(stallCount);
    send(2, 4, 0, '0, 0, '0, 0, '0, 0, "R1");
    send(2, 8, 1, fr(4), 1, fr(2), 0, '0, 3, "R1");
    @(negedge clk); #1;
    // R13: the counter moved by exactly the stalled cycles
    check(int'(stallCount) == c0 + 3, "R13", "count delta", longint'(stallCount), c0 + 3);
    idle(4);

    // R2: FP ALU -> store data
    send(2, 4, 0, '0, 0, '0, 0, '0, 0, "R2");
    send(4, 0, 1, ir(1), 0, '0, 1, fr(4), 2, "R2");
    idle(4);

    // R3: FP load -> FP ALU
    send(3, 6, 1, ir(1), 0, '0, 0, '0, 0, "R3");
    send(2, 9, 0, '0, 1, fr(6), 0, '0, 1, "R3");
    idle(4);

    // R4: FP load -> store data
    send(3, 6, 1, ir(1), 0, '0, 0, '0, 0, "R4");
    send(4, 0, 0, '0, 0, '0, 1, fr(6), 0, "R4");
    idle(4);

    // R5: integer load -> next
    send(1, 5, 1, ir(2), 0, '0, 0, '0, 0, "R5");
    send(0, 7, 1, ir(5), 0, '0, 0, '0, 1, "R5");
    idle(4);

    // R6: integer ALU -> ALU
    send(0, 3, 0, '0, 0, '0, 0, '0, 0, "R6");
    send(0, 7, 0, '0, 1, ir(3), 0, '0, 0, "R6");
    idle(4);

    // R7: integer ALU -> branch
    send(0, 3, 0, '0, 0, '0, 0, '0, 0, "R7");
    send(5, 0, 1, ir(3), 0, '0, 0, '0, 1, "R7");
    idle(4);

    // R8: store base follows the general rule
    send(1, 1, 0, '0, 0, '0, 0, '0, 0, "R8");
    send(4, 0, 1, ir(1), 0, '0, 1, fr(2), 1, "R8");
    idle(4);

    // R10: same index, other file; invalid operands ignored
    send(1, 4, 0, '0, 0, '0, 0, '0, 0, "R10");
    send(2, 9, 1, fr(4), 0, '0, 0, '0, 0, "R10");
    idle(4);
    send(2, 4, 0, '0, 0, '0, 0, '0, 0, "R10");
    send(2, 9, 0, fr(4), 0, fr(4), 0, fr(4), 0, "R10");
    idle(4);

    // R11: the younger FP load hides the older FP ALU writer
    send(2, 4, 0, '0, 0, '0, 0, '0, 0, "R11");
    send(3, 4, 1, ir(1), 0, '0, 0, '0, 0, "R11");
    send(2, 9, 1, fr(4), 0, '0, 0, '0, 1, "R11");
    idle(4);

    // R9: a withdrawn stalled candidate is never recorded
    send(2, 4, 0, '0, 0, '0, 0, '0, 0, "R9");
    step(1, 2, 6, 1, fr(4), 0, '0, 0, '0, "R9", s);
    check(s == 1'b1, "R9", "stalled", s, 1);
    idle(4);
    send(4, 0, 1, ir(1), 0, '0, 1, fr(6), 0, "R9");
    idle(4);

    // R12: reset drops an in-flight FP ALU producer
    send(2, 4, 0, '0, 0, '0, 0, '0, 0, "R12");
    doReset();
    send(2, 9, 1, fr(4), 0, '0, 0, '0, 0, "R12");
    idle(4);

    // random stream compared to the model every cycle
    for (int i = 0; i < 1500; i++) begin
      step($urandom_range(0, 9) < 8, $urandom_range(0, 5), $urandom_range(0, 3),
           $urandom_range(0, 1) == 1, {1'($urandom_range(0, 1)), 5'($urandom_range(0, 3))},
           $urandom_range(0, 2) == 1, {1'($urandom_range(0, 1)), 5'($urandom_range(0, 3))},
           $urandom_range(0, 2) == 1, {1'($urandom_range(0, 1)), 5'($urandom_range(0, 3))},
           "model", s);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule